// File: doc/BRIEF.md
# Pseudo-Static RAM Power and Deep Sleep Sequencer

This block owns the low-power mode pin of a pseudo-static RAM and tells the access controller when the memory may take cycles. After power-up it waits until the supply has been good for a set time. It then waits out the long hold that the memory needs before its first access, and only then raises `mem_ready`. While the block is not ready it holds the memory's chip enable inactive through `mem_sel_block`.

On request the block takes the memory into deep sleep. It first blocks the chip enable for a few settle cycles, then drives `mem_lowpwr_n` low for at least the minimum sleep time. On a wake request it returns the pin high and again waits out the hold time before reporting ready. A wake request that arrives before the minimum sleep time has passed is remembered and acted on once that time is over. Deep sleep destroys the stored contents, so every wake raises `contents_lost` until software acknowledges it with a write-one clear.

Top module: `psram_sleep_ctrl`

## Requirements
- R1: While reset is asserted: `mem_lowpwr_n`=1, `mem_sel_block`=1, `mem_ready`=0 and `contents_lost`=0.
- R2: `mem_ready` rises exactly SUPPLY_CYC + HOLD_CYC clock edges after `supply_ok` is first sampled high with no interruption. Here SUPPLY_CYC = ceil(SUPPLY_WAIT_NS/CLK_PERIOD_NS) and HOLD_CYC = ceil(WAKE_HOLD_NS/CLK_PERIOD_NS).
- R3: A low sample of `supply_ok` in any state returns the block to its supply wait. On the next cycle `mem_ready`=0, `mem_sel_block`=1 and `mem_lowpwr_n`=1, and the supply wait restarts in full once `supply_ok` is high again.
- R4: When `sleep_req` is sampled high in the ready state, `mem_ready` falls and `mem_sel_block` rises at that edge. `mem_lowpwr_n` falls SETTLE_CYC edges later. `mem_sel_block` is high on both sides of every change of `mem_lowpwr_n`.
- R5: `mem_lowpwr_n` stays low for at least SLEEP_CYC = ceil(SLEEP_MIN_NS/CLK_PERIOD_NS) cycles. When the wake request has already been seen, the low time is exactly SLEEP_CYC cycles.
- R6: A `wake_req` pulse sampled during the settle cycles or the minimum sleep time is held. `mem_lowpwr_n` then returns high exactly when the minimum time expires. A later pulse releases it at the edge that samples the pulse.
- R7: After `mem_lowpwr_n` returns high, `mem_ready` stays low for exactly HOLD_CYC cycles, with `mem_sel_block` high throughout.
- R8: `contents_lost` is set at the edge where `mem_lowpwr_n` returns high from sleep. It is cleared by a cycle with `lost_clr`=1. When both happen at the same edge, setting wins.
- R9: `sleep_req` has no effect outside the ready state, and `wake_req` has no effect in the ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply has reached its minimum level |
| sleep_req | input | 1 | Request to enter deep sleep |
| wake_req | input | 1 | Request to leave deep sleep |
| lost_clr | input | 1 | Write-one clear of `contents_lost` |
| mem_sel_block | output | 1 | Forces the memory chip enable inactive |
| mem_lowpwr_n | output | 1 | Memory low-power pin; low means deep sleep |
| mem_ready | output | 1 | Memory may accept access cycles |
| contents_lost | output | 1 | Stored data invalid after a sleep exit |

## Verification
All outputs decode a registered state, so each result appears in the cycle right after the edge that sampled its cause. The bench therefore drives on falling edges and samples on the next falling edge. The timed results are checked by counting falling-edge samples: SUPPLY_CYC+HOLD_CYC samples from a stable supply to ready, SETTLE_CYC+1 from the request to the first low sample of `mem_lowpwr_n`, then max(SLEEP_CYC, wake_at-2) low samples, and HOLD_CYC samples from its return high until ready. Each count is compared with a value computed from these formulas, not with an observed time.

// File: rtl/psram_sleep_pkg.sv
package psram_sleep_pkg;

  typedef enum logic [2:0] {
    ST_SUPPLY_WAIT,
    ST_PWRUP_HOLD,
    ST_READY,
    ST_SLEEP_SETTLE,
    ST_SLEEP,
    ST_WAKE_HOLD
  } sleep_state_e;

  // Round a time up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_of(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold the value maxv.
  function automatic int unsigned cnt_width(input int unsigned maxv);
    int unsigned w;
    w = $clog2(maxv + 1);
    if (w == 0) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/psram_sleep_timer.sv
module psram_sleep_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/psram_sleep_fsm.sv
module psram_sleep_fsm
  import psram_sleep_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SUPPLY_CYC = 4,
  parameter int unsigned HOLD_CYC   = 4,
  parameter int unsigned SLEEP_CYC  = 4,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             sleep_req,
  input  logic             wake_go,
  input  logic             cnt_zero,
  output sleep_state_e     state,
  output sleep_state_e     state_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             leave_sleep
);

  localparam logic [CNT_W-1:0] SUPPLY_LD = CNT_W'(SUPPLY_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SLEEP_LD  = CNT_W'(SLEEP_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  sleep_state_e state_q;

  always_comb begin
    state_nxt = state_q;
    load      = 1'b0;
    load_val  = '0;
    if (!supply_ok) begin
      state_nxt = ST_SUPPLY_WAIT;
      load      = 1'b1;
      load_val  = SUPPLY_LD;
    end else begin
      unique case (state_q)
        ST_SUPPLY_WAIT: if (cnt_zero) begin
          state_nxt = ST_PWRUP_HOLD;
          load      = 1'b1;
          load_val  = HOLD_LD;
        end
        ST_PWRUP_HOLD: if (cnt_zero) state_nxt = ST_READY;
        ST_READY: if (sleep_req) begin
          state_nxt = ST_SLEEP_SETTLE;
          load      = 1'b1;
          load_val  = SETTLE_LD;
        end
        ST_SLEEP_SETTLE: if (cnt_zero) begin
          state_nxt = ST_SLEEP;
          load      = 1'b1;
          load_val  = SLEEP_LD;
        end
        ST_SLEEP: if (cnt_zero && wake_go) begin
          state_nxt = ST_WAKE_HOLD;
          load      = 1'b1;
          load_val  = HOLD_LD;
        end
        ST_WAKE_HOLD: if (cnt_zero) state_nxt = ST_READY;
        default: begin
          state_nxt = ST_SUPPLY_WAIT;
          load      = 1'b1;
          load_val  = SUPPLY_LD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SUPPLY_WAIT;
    else        state_q <= state_nxt;
  end

  assign state       = state_q;
  assign leave_sleep = (state_q == ST_SLEEP) && (state_nxt == ST_WAKE_HOLD);

endmodule

// File: rtl/psram_sleep_flags.sv
module psram_sleep_flags
  import psram_sleep_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  sleep_state_e state,
  input  logic         wake_req,
  input  logic         leave_sleep,
  input  logic         lost_clr,
  output logic         wake_pend,
  output logic         contents_lost
);

  logic in_sleep_path;
  assign in_sleep_path = (state == ST_SLEEP_SETTLE) || (state == ST_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pend     <= 1'b0;
      contents_lost <= 1'b0;
    end else begin
      wake_pend <= in_sleep_path && !leave_sleep && (wake_pend || wake_req);
      if (leave_sleep)   contents_lost <= 1'b1;
      else if (lost_clr) contents_lost <= 1'b0;
    end
  end

endmodule

// File: rtl/psram_sleep_ctrl.sv
module psram_sleep_ctrl
  import psram_sleep_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS  = 8,
  parameter int unsigned SUPPLY_WAIT_NS = 30000,
  parameter int unsigned WAKE_HOLD_NS   = 300000,
  parameter int unsigned SLEEP_MIN_NS   = 10000,
  parameter int unsigned SETTLE_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic lost_clr,
  output logic mem_sel_block,
  output logic mem_lowpwr_n,
  output logic mem_ready,
  output logic contents_lost
);

  localparam int unsigned SUPPLY_CYC = ns_to_cycles(SUPPLY_WAIT_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC   = ns_to_cycles(WAKE_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned SLEEP_CYC  = ns_to_cycles(SLEEP_MIN_NS, CLK_PERIOD_NS);
  localparam int unsigned SETTLE_EFF = (SETTLE_CYC == 0) ? 1 : SETTLE_CYC;
  localparam int unsigned MAX_CYC    =
    max_of(max_of(SUPPLY_CYC, HOLD_CYC), max_of(SLEEP_CYC, SETTLE_EFF));
  localparam int unsigned CNT_W      = cnt_width(MAX_CYC);

  sleep_state_e     state;
  sleep_state_e     state_nxt;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             cnt_zero;
  logic             leave_sleep;
  logic             wake_pend;
  logic             wake_go;

  assign wake_go = wake_req || wake_pend;

  psram_sleep_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (SUPPLY_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt_zero (cnt_zero)
  );

  psram_sleep_fsm #(
    .CNT_W      (CNT_W),
    .SUPPLY_CYC (SUPPLY_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .SLEEP_CYC  (SLEEP_CYC),
    .SETTLE_CYC (SETTLE_EFF)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .sleep_req   (sleep_req),
    .wake_go     (wake_go),
    .cnt_zero    (cnt_zero),
    .state       (state),
    .state_nxt   (state_nxt),
    .load        (load),
    .load_val    (load_val),
    .leave_sleep (leave_sleep)
  );

  psram_sleep_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .wake_req      (wake_req),
    .leave_sleep   (leave_sleep),
    .lost_clr      (lost_clr),
    .wake_pend     (wake_pend),
    .contents_lost (contents_lost)
  );

  assign mem_ready     = (state == ST_READY);
  assign mem_sel_block = (state != ST_READY);
  assign mem_lowpwr_n  = (state != ST_SLEEP);

endmodule

// File: rtl/psram_sleep_ctrl_chk.sv
module psram_sleep_ctrl_chk #(
  parameter int unsigned SLEEP_CYC = 4,
  parameter int unsigned HOLD_CYC  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic mem_sel_block,
  input logic mem_lowpwr_n,
  input logic mem_ready,
  input logic contents_lost
);

  logic [31:0] low_run;
  logic [31:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      if (!mem_lowpwr_n) low_run <= (low_run == 32'hFFFF_FFFF) ? low_run : low_run + 1;
      else               low_run <= '0;
      if (mem_lowpwr_n && mem_sel_block)
        high_run <= (high_run == 32'hFFFF_FFFF) ? high_run : high_run + 1;
      else
        high_run <= '0;
    end
  end

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !mem_ready && mem_sel_block && mem_lowpwr_n); // R3

  AST_PIN_CHANGE_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lowpwr_n != $past(mem_lowpwr_n)) |-> (mem_sel_block && $past(mem_sel_block))); // R4

  AST_SLEEP_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_lowpwr_n) && $past(supply_ok)) |-> (low_run >= SLEEP_CYC)); // R5

  AST_HOLD_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (high_run >= HOLD_CYC)); // R7

  AST_LOST_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_lowpwr_n) && $past(supply_ok)) |-> contents_lost); // R8

endmodule

bind psram_sleep_ctrl psram_sleep_ctrl_chk #(
  .SLEEP_CYC (SLEEP_CYC),
  .HOLD_CYC  (HOLD_CYC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok     (supply_ok),
  .mem_sel_block (mem_sel_block),
  .mem_lowpwr_n  (mem_lowpwr_n),
  .mem_ready     (mem_ready),
  .contents_lost (contents_lost)
);

// File: tb/psram_sleep_ctrl_tb_top.sv
module psram_sleep_ctrl_tb_top;

  // Cycle counts restated from the chosen times: 240/8, 400/8, 160/8.
  localparam int SUP_C = 30;
  localparam int HLD_C = 50;
  localparam int SLP_C = 20;
  localparam int SET_C = 2;
  localparam int NVEC  = 6;
  // Each row: cycle index of the wake pulse, hold lost_clr high during the sleep.
  localparam int VEC [NVEC][2] = '{'{1, 0}, '{2, 0}, '{10, 1}, '{21, 0}, '{22, 0}, '{30, 0}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, lost_clr = 1'b0;
  logic mem_sel_block, mem_lowpwr_n, mem_ready, contents_lost;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  psram_sleep_ctrl #(
    .CLK_PERIOD_NS (8), .SUPPLY_WAIT_NS (240), .WAKE_HOLD_NS (400),
    .SLEEP_MIN_NS (160), .SETTLE_CYC (SET_C)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .sleep_req (sleep_req),
    .wake_req (wake_req), .lost_clr (lost_clr), .mem_sel_block (mem_sel_block),
    .mem_lowpwr_n (mem_lowpwr_n), .mem_ready (mem_ready), .contents_lost (contents_lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_ready(output int n, output int low_seen);
    n = 0; low_seen = 0;
    while (!mem_ready && n < 2000) begin
      step(); n++;
      if (!mem_lowpwr_n) low_seen++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int n, lows, first_low, low_cnt, exp_low, hc, sel_bad;
    repeat (3) @(negedge clk);
    chk("R1 lowpwr_n", mem_lowpwr_n, 1);
    chk("R1 sel_block", mem_sel_block, 1);
    chk("R1 ready", mem_ready, 0);
    chk("R1 lost", contents_lost, 0);
    rst_n = 1'b1;
    repeat (5) step();
    chk("R3 no supply keeps not ready", mem_ready, 0);
    supply_ok = 1'b1;
    repeat (10) step();
    supply_ok = 1'b0; step();
    supply_ok = 1'b1;
    wait_ready(n, lows);
    chk("R3 wait restarts after supply drop", n, SUP_C + HLD_C);

    // R9: wake request in ready has no effect
    wake_req = 1'b1; step(); wake_req = 1'b0;
    repeat (4) step();
    chk("R9 wake in ready keeps ready", mem_ready, 1);
    chk("R9 wake in ready keeps pin high", mem_lowpwr_n, 1);

    for (int k = 0; k < NVEC; k++) begin
      sleep_req = 1'b1; lost_clr = VEC[k][1][0];
      step(); sleep_req = 1'b0;
      chk("R4 ready falls at request edge", mem_ready, 0);
      chk("R4 sel_block rises at request edge", mem_sel_block, 1);
      first_low = 0; low_cnt = 0; sel_bad = 0;
      for (int i = 1; i < 400; i++) begin
        wake_req = (i == VEC[k][0]);
        if (!mem_lowpwr_n) begin
          if (first_low == 0) first_low = i;
          low_cnt++;
          if (!mem_sel_block) sel_bad++;
        end else if (first_low != 0) begin
          break;
        end
        step();
      end
      wake_req = 1'b0; lost_clr = 1'b0;
      exp_low = (VEC[k][0] - 2 > SLP_C) ? VEC[k][0] - 2 : SLP_C;
      chk("R4 pin falls after settle", first_low, SET_C + 1);
      chk("R4 sel_block held while asleep", sel_bad, 0);
      if (VEC[k][0] - 2 <= SLP_C) chk("R6 held wake, low time", low_cnt, exp_low);
      else                        chk("R5 late wake, low time", low_cnt, exp_low);
      chk("R8 lost set at wake (set beats clear)", contents_lost, 1);
      hc = 0; sel_bad = 0;
      while (!mem_ready && hc < 500) begin
        if (!mem_sel_block) sel_bad++;
        hc++; step();
      end
      chk("R7 hold cycles before ready", hc, HLD_C);
      chk("R7 sel_block during hold", sel_bad, 0);
      chk("R8 lost stays until cleared", contents_lost, 1);
      lost_clr = 1'b1; step(); lost_clr = 1'b0;
      chk("R8 lost cleared by write-one", contents_lost, 0);
    end

    // R3 supply drop in ready, R9 sleep request ignored while waiting, R2 timing
    supply_ok = 1'b0; step();
    chk("R3 drop in ready clears ready", mem_ready, 0);
    chk("R3 drop in ready blocks select", mem_sel_block, 1);
    supply_ok = 1'b1;
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    wait_ready(n, lows);
    chk("R2 supply plus hold cycles to ready", n + 1, SUP_C + HLD_C);
    chk("R9 sleep request ignored while not ready", lows, 0);
    repeat (3) step();
    chk("R9 still ready afterwards", mem_ready, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule